// File: doc/BRIEF.md
# Daylight Saving Time Adjuster

The block sits beside a BCD real-time clock and watches its month, weekday, date, hour, minute and second fields. It holds two programmable rules: a spring rule that asks the clock to step its hour forward by one, and an autumn rule that asks it to step the hour back by one. Each rule names a month and an hour. It also names either a fixed calendar date or a weekday within a given week of the month. The clock counter acts on the two one-cycle request pulses. The block does not change any time field itself.

The rules sit in eight byte-wide registers on a small parallel bus. Writes are synchronous and reads are combinational. A single enable bit in the spring month register turns the whole function on or off. After the autumn step fires, the block remembers it so that the repeated hour cannot trigger a second step back. That memory is dropped as soon as the clock's date moves off the date on which the step fired.

Register map (address: content): 0 spring month (bit 7 = global enable, bits 4:0 BCD month); 1 spring day; 2 spring date (bits 5:0 BCD); 3 spring hour; 4 autumn month (bits 4:0); 5 autumn day; 6 autumn date; 7 autumn hour. A day register holds the weekday (0 = Sunday … 6) in bits 2:0, the week of the month in bits 5:3, and the weekday-mode select in bit 6. An hour register holds the 12/24-hour format bit in bit 7 and the BCD hour in bits 5:0, in the same encoding as the clock's hour field.

Top module: `dst_adjuster`

## Requirements
- R1: After reset the registers read spring 04h, 48h, 01h, 02h (addresses 0–3) and autumn 10h, 00h, 01h, 02h (addresses 4–7). The global enable is therefore off.
- R2: A byte written with `reg_wr` at an address is returned on `reg_rdata` when that address is presented after the write edge.
- R3: While bit 7 of register 0 is 0, neither `hour_inc` nor `hour_dec` ever pulses.
- R4: With the function enabled, `hour_inc` pulses high for one cycle, one clock after a `tick`, when all of these hold on that tick: minutes and seconds are 00h, the hour field equals the spring hour register in bits 7 and 5:0, the month equals spring month bits 4:0, and the day condition holds.
- R5: When day bit 6 is 1, the day condition holds when the weekday equals bits 2:0 and (date−1)/7+1 equals bits 5:3. The date register is ignored in this case.
- R6: When day bit 6 is 0, the day condition holds when the date equals the date register bits 5:0. Weekday and week are ignored in this case.
- R7: A rule never fires when its hour format bit (bit 7) differs from the clock hour's bit 7, including in 12-hour mode.
- R8: No request is made without `tick`, or when minutes or seconds are not 00h.
- R9: With the function enabled, `hour_dec` pulses for one cycle, one clock after a tick, when the autumn rule matches under the same conditions as R4.
- R10: Once `hour_dec` has fired, further autumn matches are ignored until the clock's date differs from the date on which it fired. After that, the autumn rule can fire again.
- R11: If both rules match on the same tick, only `hour_inc` pulses, and the autumn latch of R10 is not set.
- R12: `hour_inc` and `hour_dec` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Once-per-second strobe from the clock counter |
| cur_sec | input | 8 | BCD seconds |
| cur_min | input | 8 | BCD minutes |
| cur_hour | input | 8 | Clock hour: bit 7 format, bits 5:0 BCD hour |
| cur_dow | input | 3 | Weekday, 0 = Sunday |
| cur_date | input | 8 | BCD date 01–31 |
| cur_mon | input | 8 | BCD month 01–12 |
| reg_addr | input | 3 | Register address |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| hour_inc | output | 1 | One-cycle request to step the hour forward |
| hour_dec | output | 1 | One-cycle request to step the hour back |

## Verification
The two functions that can land on the same cycle are the spring step and the autumn step. This happens when both rules are programmed to the same month, date and hour. The bench provokes it by loading identical rules and ticking at the shared instant. It then expects `hour_inc` alone. It next moves the spring rule away and ticks at the same instant again. A `hour_dec` on that tick shows that the suppressed autumn match did not set the repeat latch.

// File: rtl/dst_pkg.sv
// Package: shared constants, register indices, reset values and the rule type
// for the daylight saving time adjuster. Assumes 8-bit BCD clock fields.
package dst_pkg;
    localparam int REG_W    = 8;
    localparam int NUM_REGS = 8;
    localparam int ADDR_W   = $clog2(NUM_REGS);
    localparam int RULE_REGS = 4;

    // Register slot within one rule
    localparam int SLOT_MON  = 0;
    localparam int SLOT_DAY  = 1;
    localparam int SLOT_DATE = 2;
    localparam int SLOT_HOUR = 3;

    // Rule base addresses
    localparam int SPRING_BASE = 0;
    localparam int AUTUMN_BASE = SPRING_BASE + RULE_REGS;

    // Bit positions
    localparam int EN_BIT     = 7;
    localparam int DAYSEL_BIT = 6;
    localparam int FMT_BIT    = 7;

    typedef struct packed {
        logic [REG_W-1:0] mon;
        logic [REG_W-1:0] day;
        logic [REG_W-1:0] date;
        logic [REG_W-1:0] hour;
    } dst_rule_t;

    // Reset value of each register
    function automatic logic [REG_W-1:0] reg_default(input int idx);
        case (idx)
            SPRING_BASE + SLOT_MON:  return 8'h04;
            SPRING_BASE + SLOT_DAY:  return 8'h48;
            SPRING_BASE + SLOT_DATE: return 8'h01;
            SPRING_BASE + SLOT_HOUR: return 8'h02;
            AUTUMN_BASE + SLOT_MON:  return 8'h10;
            AUTUMN_BASE + SLOT_DAY:  return 8'h00;
            AUTUMN_BASE + SLOT_DATE: return 8'h01;
            AUTUMN_BASE + SLOT_HOUR: return 8'h02;
            default:                 return '0;
        endcase
    endfunction
endpackage

// File: rtl/dst_regfile.sv
// Register file: NUM_REGS byte registers with per-index reset values.
// Writes land on the clock edge; the read port is combinational.
// Assumes the address is always in range (NUM_REGS is a power of two).
module dst_regfile
    import dst_pkg::*;
#(
    parameter int N  = NUM_REGS,
    parameter int W  = REG_W,
    parameter int AW = ADDR_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [AW-1:0]         addr,
    input  logic                  wr,
    input  logic [W-1:0]          wdata,
    output logic [W-1:0]          rdata,
    output logic [N-1:0][W-1:0]   regs_o
);
    logic [N-1:0][W-1:0] regs_q;

    for (genvar i = 0; i < N; i++) begin : g_reg
        // Hold one register: reset value or written byte
        always_ff @(posedge clk) begin
            if (!rst_n)
                regs_q[i] <= W'(reg_default(i));
            else if (wr && addr == AW'(i))
                regs_q[i] <= wdata;
        end
    end

    // Read mux
    always_comb rdata = regs_q[addr];

    assign regs_o = regs_q;
endmodule

// File: rtl/dst_week_calc.sv
// Week-of-month from a BCD date: (date-1)/7+1, giving 1..5.
// A date of 00 yields week 0, which matches no valid programmed week.
module dst_week_calc (
    input  logic [7:0] date_bcd,
    output logic [2:0] week
);
    logic [5:0] bin;

    // Convert BCD date to binary and bucket it into weeks
    always_comb begin
        bin = ({4'b0, date_bcd[5:4]} * 6'd10) + {2'b0, date_bcd[3:0]};
        if (bin == 6'd0)       week = 3'd0;
        else if (bin <= 6'd7)  week = 3'd1;
        else if (bin <= 6'd14) week = 3'd2;
        else if (bin <= 6'd21) week = 3'd3;
        else if (bin <= 6'd28) week = 3'd4;
        else                   week = 3'd5;
    end
endmodule

// File: rtl/dst_rule_match.sv
// Calendar match for one rule: month, day (weekday-in-week or fixed date)
// and hour including the 12/24 format bit. Purely combinational; the caller
// qualifies the result with the tick and the top-of-hour condition.
module dst_rule_match
    import dst_pkg::*;
(
    input  dst_rule_t   rule,
    input  logic [7:0]  cur_mon,
    input  logic [2:0]  cur_dow,
    input  logic [7:0]  cur_date,
    input  logic [7:0]  cur_hour,
    output logic        hit
);
    logic [2:0] cur_week;
    logic       mon_ok, day_ok, hour_ok;

    dst_week_calc u_week (
        .date_bcd (cur_date),
        .week     (cur_week)
    );

    // Compare each field against the rule
    always_comb begin
        mon_ok  = ({3'b0, rule.mon[4:0]} == cur_mon);
        hour_ok = ({rule.hour[FMT_BIT], rule.hour[5:0]} ==
                   {cur_hour[FMT_BIT], cur_hour[5:0]});
        if (rule.day[DAYSEL_BIT])
            day_ok = (rule.day[2:0] == cur_dow) && (rule.day[5:3] == cur_week);
        else
            day_ok = ({2'b0, rule.date[5:0]} == cur_date);
        hit = mon_ok && day_ok && hour_ok;
    end
endmodule

// File: rtl/dst_adjuster.sv
// Daylight saving time adjuster top. Holds the spring and autumn rules,
// checks them on each tick at minute 00 second 00, and issues one-cycle
// step requests. Spring wins when both rules match on one tick. An autumn
// latch blocks a repeat step on the same date. Assumes the time inputs are
// stable around the tick and in valid BCD.
module dst_adjuster
    import dst_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic [7:0]        cur_sec,
    input  logic [7:0]        cur_min,
    input  logic [7:0]        cur_hour,
    input  logic [2:0]        cur_dow,
    input  logic [7:0]        cur_date,
    input  logic [7:0]        cur_mon,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    output logic              hour_inc,
    output logic              hour_dec
);
    logic [NUM_REGS-1:0][REG_W-1:0] regs;
    dst_rule_t rules [2];
    logic [1:0] rule_hit;
    logic       fwd_en;
    logic       top_of_hour;
    logic       fire_fwd, fire_rev;
    logic       rev_block;
    logic [7:0] rev_date_q;

    dst_regfile u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .addr   (reg_addr),
        .wr     (reg_wr),
        .wdata  (reg_wdata),
        .rdata  (reg_rdata),
        .regs_o (regs)
    );

    // One matcher per rule: index 0 spring, index 1 autumn
    for (genvar r = 0; r < 2; r++) begin : g_rule
        localparam int BASE = r * RULE_REGS;
        always_comb begin
            rules[r].mon  = regs[BASE + SLOT_MON];
            rules[r].day  = regs[BASE + SLOT_DAY];
            rules[r].date = regs[BASE + SLOT_DATE];
            rules[r].hour = regs[BASE + SLOT_HOUR];
        end
        dst_rule_match u_match (
            .rule     (rules[r]),
            .cur_mon  (cur_mon),
            .cur_dow  (cur_dow),
            .cur_date (cur_date),
            .cur_hour (cur_hour),
            .hit      (rule_hit[r])
        );
    end

    // Qualify the matches with enable, tick, top of hour, priority and latch
    always_comb begin
        fwd_en      = regs[SPRING_BASE + SLOT_MON][EN_BIT];
        top_of_hour = (cur_min == 8'h00) && (cur_sec == 8'h00);
        fire_fwd    = tick && fwd_en && top_of_hour && rule_hit[0];
        fire_rev    = tick && fwd_en && top_of_hour && rule_hit[1]
                      && !rev_block && !fire_fwd;
    end

    // Register the step requests
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hour_inc <= 1'b0;
            hour_dec <= 1'b0;
        end else begin
            hour_inc <= fire_fwd;
            hour_dec <= fire_rev;
        end
    end

    // Autumn repeat latch: set on firing, cleared once the date moves on
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rev_block  <= 1'b0;
            rev_date_q <= '0;
        end else if (fire_rev) begin
            rev_block  <= 1'b1;
            rev_date_q <= cur_date;
        end else if (rev_block && cur_date != rev_date_q) begin
            rev_block  <= 1'b0;
        end
    end
endmodule

// File: rtl/dst_adjuster_chk.sv
// Checker for dst_adjuster: temporal properties on the step requests.
module dst_adjuster_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       tick,
    input logic [7:0] cur_min,
    input logic [7:0] cur_sec,
    input logic       hour_inc,
    input logic       hour_dec,
    input logic       glob_en
);
    // R12
    excl_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(hour_inc && hour_dec));

    // R4
    inc_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hour_inc |-> ($past(tick) && $past(cur_min) == 8'h00 && $past(cur_sec) == 8'h00));

    // R9
    dec_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hour_dec |-> ($past(tick) && $past(cur_min) == 8'h00 && $past(cur_sec) == 8'h00));

    // R3
    enable_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hour_inc || hour_dec) |-> $past(glob_en));

    // R10
    dec_no_repeat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hour_dec |=> !hour_dec);
endmodule

bind dst_adjuster dst_adjuster_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .cur_min  (cur_min),
    .cur_sec  (cur_sec),
    .hour_inc (hour_inc),
    .hour_dec (hour_dec),
    .glob_en  (fwd_en)
);

// File: tb/dst_adjuster_bench.sv
`timescale 1ns/1ps
module dst_adjuster_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic [7:0] cur_sec = '0, cur_min = '0, cur_hour = '0, cur_date = 8'h01, cur_mon = 8'h01;
    logic [2:0] cur_dow = '0;
    logic [2:0] reg_addr = '0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       hour_inc, hour_dec;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    dst_adjuster u_dst_adjuster (.*);

    always #5 clk = ~clk;

    function automatic logic [7:0] bcd(input int v);
        return 8'((v / 10) * 16 + (v % 10));
    endfunction

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input logic [2:0] a, input logic [7:0] exp);
        @(negedge clk);
        reg_addr = a;
        #1 chk(tag, reg_rdata, exp);
    endtask

    // Present a time, optionally tick, return {inc,dec} one clock later
    task automatic step(input logic [7:0] mo, input logic [2:0] dw, input logic [7:0] dt,
                        input logic [7:0] hr, input logic [7:0] mi, input logic [7:0] se,
                        input bit tk, output logic [1:0] res);
        @(negedge clk);
        cur_mon = mo; cur_dow = dw; cur_date = dt; cur_hour = hr;
        cur_min = mi; cur_sec = se; tick = tk;
        @(negedge clk);
        res = {hour_inc, hour_dec};
        tick = 1'b0;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [1:0] r;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset values
        rd_chk("R1 spring month", 3'd0, 8'h04);
        rd_chk("R1 spring day",   3'd1, 8'h48);
        rd_chk("R1 spring date",  3'd2, 8'h01);
        rd_chk("R1 spring hour",  3'd3, 8'h02);
        rd_chk("R1 autumn month", 3'd4, 8'h10);
        rd_chk("R1 autumn day",   3'd5, 8'h00);
        rd_chk("R1 autumn date",  3'd6, 8'h01);
        rd_chk("R1 autumn hour",  3'd7, 8'h02);

        // R2 write and read back
        wr_reg(3'd2, 8'h5A); rd_chk("R2 readback date", 3'd2, 8'h5A);
        wr_reg(3'd7, 8'hA5); rd_chk("R2 readback hour", 3'd7, 8'hA5);
        wr_reg(3'd7, 8'h02);

        // R3 disabled: autumn default instant and a spring instant do nothing
        step(8'h10, 3'd0, 8'h01, 8'h02, 8'h00, 8'h00, 1'b1, r);
        chk("R3 disabled autumn", {6'b0, r}, 8'h00);
        step(8'h04, 3'd0, 8'h01, 8'h02, 8'h00, 8'h00, 1'b1, r);
        chk("R3 disabled spring", {6'b0, r}, 8'h00);

        // R5 weekday mode sweep: March, second week, Sunday, 02h
        wr_reg(3'd0, 8'h83);
        wr_reg(3'd1, 8'h50);
        wr_reg(3'd2, 8'h15);
        for (int d = 1; d <= 31; d++) begin
            for (int w = 0; w < 7; w++) begin
                logic [1:0] e;
                e = {(((d - 1) / 7 + 1) == 2 && w == 0), 1'b0};
                step(8'h03, 3'(w), bcd(d), 8'h02, 8'h00, 8'h00, 1'b1, r);
                chk($sformatf("R5 R4 week mode d=%0d w=%0d", d, w), {6'b0, r}, {6'b0, e});
            end
        end

        // R6 date mode sweep: date 15 regardless of weekday
        wr_reg(3'd1, 8'h10);
        for (int d = 1; d <= 31; d++) begin
            for (int w = 0; w < 7; w++) begin
                logic [1:0] e;
                e = {(d == 15), 1'b0};
                step(8'h03, 3'(w), bcd(d), 8'h02, 8'h00, 8'h00, 1'b1, r);
                chk($sformatf("R6 date mode d=%0d w=%0d", d, w), {6'b0, r}, {6'b0, e});
            end
        end

        // R4 wrong month and wrong hour
        step(8'h04, 3'd0, 8'h15, 8'h02, 8'h00, 8'h00, 1'b1, r);
        chk("R4 wrong month", {6'b0, r}, 8'h00);
        step(8'h03, 3'd0, 8'h15, 8'h03, 8'h00, 8'h00, 1'b1, r);
        chk("R4 wrong hour", {6'b0, r}, 8'h00);

        // R7 format bit
        step(8'h03, 3'd0, 8'h15, 8'h82, 8'h00, 8'h00, 1'b1, r);
        chk("R7 clock 12h rule 24h", {6'b0, r}, 8'h00);
        wr_reg(3'd3, 8'h82);
        step(8'h03, 3'd0, 8'h15, 8'h02, 8'h00, 8'h00, 1'b1, r);
        chk("R7 clock 24h rule 12h", {6'b0, r}, 8'h00);
        step(8'h03, 3'd0, 8'h15, 8'h82, 8'h00, 8'h00, 1'b1, r);
        chk("R7 both 12h", {6'b0, r}, 8'h02);
        wr_reg(3'd3, 8'h02);

        // R8 minutes, seconds, no tick
        step(8'h03, 3'd0, 8'h15, 8'h02, 8'h01, 8'h00, 1'b1, r);
        chk("R8 minute 01", {6'b0, r}, 8'h00);
        step(8'h03, 3'd0, 8'h15, 8'h02, 8'h00, 8'h30, 1'b1, r);
        chk("R8 second 30", {6'b0, r}, 8'h00);
        step(8'h03, 3'd0, 8'h15, 8'h02, 8'h00, 8'h00, 1'b0, r);
        chk("R8 no tick", {6'b0, r}, 8'h00);

        // R9 autumn fires at defaults; R10 repeat blocked then released
        step(8'h10, 3'd3, 8'h01, 8'h02, 8'h00, 8'h00, 1'b1, r);
        chk("R9 autumn step", {6'b0, r}, 8'h01);
        step(8'h10, 3'd3, 8'h01, 8'h02, 8'h00, 8'h00, 1'b1, r);
        chk("R10 repeat blocked", {6'b0, r}, 8'h00);
        step(8'h10, 3'd4, 8'h02, 8'h05, 8'h00, 8'h00, 1'b1, r);
        chk("R10 next day quiet", {6'b0, r}, 8'h00);
        step(8'h10, 3'd3, 8'h01, 8'h02, 8'h00, 8'h00, 1'b1, r);
        chk("R10 released", {6'b0, r}, 8'h01);
        step(8'h10, 3'd4, 8'h02, 8'h05, 8'h00, 8'h00, 1'b1, r);

        // R11 both rules on the same tick
        wr_reg(3'd0, 8'h90);
        wr_reg(3'd1, 8'h00);
        wr_reg(3'd2, 8'h01);
        step(8'h10, 3'd3, 8'h01, 8'h02, 8'h00, 8'h00, 1'b1, r);
        chk("R11 R12 coincident spring wins", {6'b0, r}, 8'h02);
        wr_reg(3'd0, 8'h83);
        step(8'h10, 3'd3, 8'h01, 8'h02, 8'h00, 8'h00, 1'b1, r);
        chk("R11 latch not set", {6'b0, r}, 8'h01);

        // R3 enable cleared again
        step(8'h10, 3'd4, 8'h02, 8'h05, 8'h00, 8'h00, 1'b1, r);
        wr_reg(3'd0, 8'h03);
        step(8'h10, 3'd3, 8'h01, 8'h02, 8'h00, 8'h00, 1'b1, r);
        chk("R3 disabled after use", {6'b0, r}, 8'h00);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule